// File: doc/BRIEF.md
# SPI Memory Command Front End

This block is the serial target side of a small byte-addressed nonvolatile memory. It sits behind a four-wire SPI port that runs in clock mode 0 or mode 3 and turns the serial stream into requests for a page write engine and a read port of the storage array. A faster system clock oversamples the serial clock, the select and the pause input through two-flop synchronizers. Serial data is taken on rising serial-clock edges and the output changes on falling edges, most significant bit first.

Each transaction opens with a falling select and closes with a rising select. The first byte is an opcode. Six opcodes are understood: set the write-enable latch, clear it, read the status byte, write the status byte, read the array and write the array. For the two array commands the ninth address bit rides in bit 3 of the opcode and a second byte holds the low eight address bits. Any other opcode makes the block silent until the select rises again. A pause input holds the transaction in place without ending it. Storage, programming time and protection decisions stay outside and are reached through the read port, the write-byte port, the commit pulse, the status-write pulse and the busy input.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset, and whenever the synchronized select is high, the output enable `spi_miso_oe` is 0, the write-enable latch is 0 after reset, and no write request is made.
- R2: Input bits are captured on rising serial-clock edges and output bits change on falling edges, both most significant bit first; the output enable stays 0 while opcode and address bits are being received.
- R3: Opcode 0x05 shifts out the status byte from the falling edge after its last opcode bit: bits 7..2 are `status_hi`, bit 1 is the write-enable latch, bit 0 is `busy`; the byte repeats while the clock keeps running, and it works while `busy` is 1.
- R4: Opcode 0000_A011 followed by an address byte streams array bytes from address {A, address byte}; the address rises by one after each byte and wraps from 0x1FF to 0x000.
- R5: Opcode 0x06 sets and 0x04 clears the write-enable latch, only when the select rises right after exactly 8 received bits; any further bit cancels the effect.
- R6: Opcode 0000_A010 followed by an address byte forwards every complete data byte on `wr_valid`, `wr_addr`, `wr_data` when the latch is 1; the low PAGE_W address bits step by one and wrap inside the page while the upper bits stay; with the latch at 0 nothing is forwarded.
- R7: At the rising select after an array write with at least one forwarded byte, `wr_commit` pulses for one cycle and the latch returns to 0.
- R8: Opcode 0x01 followed by a data byte pulses `sr_wr_valid` with that byte on `sr_wr_data` at the rising select when the latch is 1, and the latch returns to 0.
- R9: Any other opcode is ignored: the output enable stays 0 and no latch change, write or status write follows.
- R10: While `busy` is 1 at the end of the opcode, every opcode except 0x05 is ignored.
- R11: The pause input is taken and released only while the serial clock is low; while paused the output enable is 0, clock edges and input bits are ignored, and the transaction resumes unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_clk | input | 1 | Serial clock from the host |
| spi_sel_n | input | 1 | Active-low target select |
| spi_pause_n | input | 1 | Active-low pause request |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso; 0 means high impedance |
| busy | input | 1 | Internal write cycle in progress |
| status_hi | input | 6 | Upper six status bits supplied by the write engine |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array byte at mem_rd_addr, combinational |
| wr_valid | output | 1 | One-cycle pulse: a data byte for the page buffer |
| wr_addr | output | ADDR_W | Address of the forwarded byte |
| wr_data | output | 8 | Forwarded data byte |
| wr_commit | output | 1 | One-cycle pulse: start the programming cycle |
| sr_wr_valid | output | 1 | One-cycle pulse: new status byte |
| sr_wr_data | output | 8 | Status byte received |

## Verification
A wrong decoder state shows up within one byte time: a misread opcode either leaves the output enable at 0 where status or array data is due, or opens it where the line must float. A wrong read address counter appears as a mismatching byte at the next byte boundary, and a wrong page step shows up in the address of the next forwarded write byte. A latch that sets or clears on the wrong bit count is only seen at the ports through a later status read or a missing commit, so every latch-changing transaction is followed by a status read.

// File: rtl/spi_fe_pkg.sv
`timescale 1ns/1ps
package spi_fe_pkg;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_RDATA, ST_STAT, ST_WDATA, ST_SRDATA, ST_DONE, ST_IGN
  } fe_state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WEN_SET, CMD_WEN_CLR, CMD_STAT_RD, CMD_STAT_WR, CMD_READ, CMD_WRITE
  } cmd_e;

  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_HI_MASK = 8'hF7;  // bit 3 carries an address bit

  function automatic cmd_e decode_op(input logic [7:0] op);
    cmd_e c;
    if (op == OP_WEN_SET)                      c = CMD_WEN_SET;
    else if (op == OP_WEN_CLR)                 c = CMD_WEN_CLR;
    else if (op == OP_STAT_RD)                 c = CMD_STAT_RD;
    else if (op == OP_STAT_WR)                 c = CMD_STAT_WR;
    else if ((op & OP_HI_MASK) == OP_READ)     c = CMD_READ;
    else if ((op & OP_HI_MASK) == OP_WRITE)    c = CMD_WRITE;
    else                                       c = CMD_NONE;
    return c;
  endfunction

  // Step the low pw bits of an address, keeping the upper bits.
  function automatic logic [15:0] page_step(input logic [15:0] a, input int unsigned pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
`timescale 1ns/1ps
module spi_fe_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta     <= RST_VAL[g];
        lvl[g]   <= RST_VAL[g];
        lvl_d[g] <= RST_VAL[g];
      end else begin
        meta     <= din[g];
        lvl[g]   <= meta;
        lvl_d[g] <= lvl[g];
      end
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
`timescale 1ns/1ps
module spi_fe_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_lvl,
  input  logic       bit_fall,
  input  logic       active,
  input  logic       pause_q,
  input  logic [7:0] byte_in,
  output logic       load,
  output logic       miso,
  output logic       miso_oe
);
  logic [2:0] pos;
  logic [6:0] sr;
  logic       drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      sr   <= '0;
      miso <= 1'b0;
      drv  <= 1'b0;
      load <= 1'b0;
    end else begin
      load <= 1'b0;
      if (sel_lvl) begin
        pos <= '0;
        drv <= 1'b0;
      end else if (bit_fall && active) begin
        if (pos == 3'd0) begin
          miso <= byte_in[7];
          sr   <= byte_in[6:0];
          load <= 1'b1;
        end else begin
          miso <= sr[6];
          sr   <= {sr[5:0], 1'b0};
        end
        pos <= pos + 3'd1;
        drv <= 1'b1;
      end
    end
  end

  assign miso_oe = drv && !pause_q && !sel_lvl;
endmodule

// File: rtl/spi_fe_ctrl.sv
`timescale 1ns/1ps
module spi_fe_ctrl
  import spi_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,  // 8 or 9
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl,
  input  logic              sclk_lvl,
  input  logic              pause_lvl,
  input  logic              din_lvl,
  input  logic              bit_rise,
  input  logic              sel_rise,
  input  logic              busy,
  input  logic              tx_load,
  input  logic [5:0]        status_hi,
  input  logic [7:0]        mem_rd_data,
  output logic              pause_q,
  output logic              tx_active,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              sr_wr_valid,
  output logic [7:0]        sr_wr_data
);
  fe_state_e         st;
  logic [2:0]        bitcnt;
  logic [6:0]        sh;
  logic              op_a8, op_rd, wen_q, set_wen, wbytes, sr_have;
  logic [ADDR_W-1:0] addr_q;

  logic [7:0] in_byte;
  logic       byte_done;
  cmd_e       cmd;
  logic [8:0] addr_full;

  assign in_byte   = {sh, din_lvl};
  assign byte_done = bit_rise && (bitcnt == 3'd7);
  assign cmd       = decode_op(in_byte);
  assign addr_full = {op_a8, in_byte};

  // Pause is taken and released only while the serial clock is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pause_q <= 1'b0;
    else if (sel_lvl)  pause_q <= 1'b0;
    else if (!sclk_lvl) pause_q <= !pause_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC; bitcnt <= '0; sh <= '0;
      op_a8 <= 1'b0; op_rd <= 1'b0; wen_q <= 1'b0; set_wen <= 1'b0;
      wbytes <= 1'b0; sr_have <= 1'b0; addr_q <= '0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
      sr_wr_valid <= 1'b0; sr_wr_data <= '0;
    end else begin
      wr_valid    <= 1'b0;
      wr_commit   <= 1'b0;
      sr_wr_valid <= 1'b0;
      if (sel_lvl) begin
        if (sel_rise) begin
          if (st == ST_DONE) wen_q <= set_wen;
          else if (st == ST_WDATA && wbytes && wen_q) begin
            wr_commit <= 1'b1;
            wen_q     <= 1'b0;
          end else if (sr_have && wen_q) begin
            sr_wr_valid <= 1'b1;
            wen_q       <= 1'b0;
          end
        end
        st <= ST_OPC; bitcnt <= '0; wbytes <= 1'b0; sr_have <= 1'b0;
      end else begin
        if (bit_rise) begin
          sh     <= in_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (st == ST_DONE) st <= ST_IGN;
        end
        if (byte_done) begin
          unique case (st)
            ST_OPC: begin
              if (busy && cmd != CMD_STAT_RD) st <= ST_IGN;
              else begin
                unique case (cmd)
                  CMD_STAT_RD: st <= ST_STAT;
                  CMD_WEN_SET: begin st <= ST_DONE; set_wen <= 1'b1; end
                  CMD_WEN_CLR: begin st <= ST_DONE; set_wen <= 1'b0; end
                  CMD_STAT_WR: st <= ST_SRDATA;
                  CMD_READ, CMD_WRITE: begin
                    op_a8 <= in_byte[3];
                    op_rd <= (cmd == CMD_READ);
                    st    <= ST_ADDR;
                  end
                  default: st <= ST_IGN;
                endcase
              end
            end
            ST_ADDR: begin
              addr_q <= addr_full[ADDR_W-1:0];
              st     <= op_rd ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: begin
              if (wen_q) begin
                wr_valid <= 1'b1;
                wr_addr  <= addr_q;
                wr_data  <= in_byte;
                wbytes   <= 1'b1;
              end
              addr_q <= ADDR_W'(page_step(16'(addr_q), PAGE_W));
            end
            ST_SRDATA: begin
              sr_wr_data <= in_byte;
              sr_have    <= 1'b1;
              st         <= ST_IGN;
            end
            default: ;
          endcase
        end
        if (tx_load && st == ST_RDATA) addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign tx_active   = (st == ST_RDATA) || (st == ST_STAT);
  assign tx_byte     = (st == ST_STAT) ? {status_hi, wen_q, busy} : mem_rd_data;
  assign mem_rd_addr = addr_q;
endmodule

// File: rtl/spi_mem_frontend.sv
`timescale 1ns/1ps
module spi_mem_frontend #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_clk,
  input  logic              spi_sel_n,
  input  logic              spi_pause_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              busy,
  input  logic [5:0]        status_hi,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              sr_wr_valid,
  output logic [7:0]        sr_wr_data
);
  localparam int unsigned NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0110;  // {mosi, pause_n, sel_n, clk}

  logic [NSYNC-1:0] s_lvl, s_dly;
  logic sclk_lvl, sel_lvl, pause_lvl, din_lvl;
  logic sclk_rise, sclk_fall, sel_rise;
  logic pause_q, bit_rise, bit_fall;
  logic tx_active, tx_load;
  logic [7:0] tx_byte;

  spi_fe_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .din({spi_mosi, spi_pause_n, spi_sel_n, spi_clk}),
    .lvl(s_lvl), .lvl_d(s_dly)
  );

  assign sclk_lvl  = s_lvl[0];
  assign sel_lvl   = s_lvl[1];
  assign pause_lvl = s_lvl[2];
  assign din_lvl   = s_lvl[3];
  assign sclk_rise = s_lvl[0] && !s_dly[0];
  assign sclk_fall = !s_lvl[0] && s_dly[0];
  assign sel_rise  = s_lvl[1] && !s_dly[1];
  assign bit_rise  = sclk_rise && !pause_q && !sel_lvl;
  assign bit_fall  = sclk_fall && !pause_q && !sel_lvl;

  spi_fe_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sel_lvl(sel_lvl), .sclk_lvl(sclk_lvl),
    .pause_lvl(pause_lvl), .din_lvl(din_lvl), .bit_rise(bit_rise),
    .sel_rise(sel_rise), .busy(busy), .tx_load(tx_load), .status_hi(status_hi),
    .mem_rd_data(mem_rd_data), .pause_q(pause_q), .tx_active(tx_active),
    .tx_byte(tx_byte), .mem_rd_addr(mem_rd_addr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data)
  );

  spi_fe_tx tx_i (
    .clk(clk), .rst_n(rst_n), .sel_lvl(sel_lvl), .bit_fall(bit_fall),
    .active(tx_active), .pause_q(pause_q), .byte_in(tx_byte), .load(tx_load),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );
endmodule

// File: rtl/spi_mem_frontend_chk.sv
`timescale 1ns/1ps
module spi_mem_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_lvl,
  input logic sclk_lvl,
  input logic pause_q,
  input logic sel_rise,
  input logic bit_rise,
  input logic spi_miso_oe,
  input logic wr_valid,
  input logic wr_commit,
  input logic sr_wr_valid
);
  a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lvl |-> !spi_miso_oe);

  a_r11_pause_floats: assert property (@(posedge clk) disable iff (!rst_n)
    pause_q |-> !spi_miso_oe);

  a_r11_pause_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pause_q) |-> (!$past(sclk_lvl) || $past(sel_lvl)));

  a_r7_commit_at_sel_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(sel_rise));

  a_r8_status_at_sel_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_valid |-> $past(sel_rise));

  a_r6_byte_on_clk_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(bit_rise));

  a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, wr_commit, sr_wr_valid}));
endmodule

bind spi_mem_frontend spi_mem_frontend_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel_lvl(sel_lvl), .sclk_lvl(sclk_lvl),
  .pause_q(pause_q), .sel_rise(sel_rise), .bit_rise(bit_rise),
  .spi_miso_oe(spi_miso_oe), .wr_valid(wr_valid), .wr_commit(wr_commit),
  .sr_wr_valid(sr_wr_valid)
);

// File: tb/spi_mem_frontend_tb_top.sv
`timescale 1ns/1ps
module spi_mem_frontend_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_clk = 1'b0, spi_sel_n = 1'b1, spi_pause_n = 1'b1, spi_mosi = 1'b0;
  logic busy = 1'b0;
  logic [5:0] status_hi = 6'h2A;
  logic spi_miso, spi_miso_oe;
  logic [8:0] mem_rd_addr;
  logic [7:0] mem_rd_data;
  logic wr_valid, wr_commit, sr_wr_valid;
  logic [8:0] wr_addr;
  logic [7:0] wr_data, sr_wr_data;

  always #2 clk = ~clk;  // 250 MHz

  spi_mem_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_pause_n(spi_pause_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .busy(busy), .status_hi(status_hi),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data)
  );

  // Array model: contents follow a formula the bench can recompute.
  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction
  logic [7:0] mem [0:511];
  initial for (int i = 0; i < 512; i++) mem[i] = pattern(i);
  assign mem_rd_data = mem[mem_rd_addr];

  // Reference log of what the write side received.
  int wq[$];
  int commits = 0, srw_cnt = 0;
  logic [7:0] srw_last = 8'h00;
  always @(posedge clk) begin
    if (wr_valid) wq.push_back({15'd0, wr_addr, wr_data});
    if (wr_commit) commits++;
    if (sr_wr_valid) begin srw_cnt++; srw_last = sr_wr_data; end
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One byte, MSB first; optional pause before bit index pause_at.
  task automatic xfer(input logic [7:0] tx, input int pause_at,
                      output logic [7:0] rx, output bit oe_any, output bit oe_all);
    oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      if (i == pause_at) begin
        spi_pause_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(spi_miso_oe == 1'b0, "R11 output floats while paused", spi_miso_oe, 0);
        for (int k = 0; k < 2; k++) begin
          spi_mosi = ~spi_mosi; spi_clk = 1'b1;
          repeat (6) @(negedge clk);
          spi_clk = 1'b0;
          repeat (6) @(negedge clk);
        end
        spi_pause_n = 1'b1;
        repeat (8) @(negedge clk);
      end
      spi_mosi = tx[i];
      repeat (6) @(negedge clk);
      rx[i] = spi_miso;
      oe_any = oe_any | spi_miso_oe;
      oe_all = oe_all & spi_miso_oe;
      spi_clk = 1'b1;
      repeat (6) @(negedge clk);
      spi_clk = 1'b0;
    end
  endtask

  task automatic sel_on;
    @(negedge clk); spi_sel_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask
  task automatic sel_off;
    repeat (6) @(negedge clk); spi_sel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  logic [7:0] rx;
  bit a, b;

  task automatic cmd1(input logic [7:0] op);
    sel_on; xfer(op, -1, rx, a, b); sel_off;
  endtask

  task automatic status_read(input logic [7:0] exp, input string tag);
    sel_on;
    xfer(8'h05, -1, rx, a, b);
    chk(!a, {tag, " R2 no drive during opcode"}, a, 0);
    xfer(8'h00, -1, rx, a, b);
    chk(b && rx == exp, {tag, " R3 status byte"}, rx, exp);
    xfer(8'h00, -1, rx, a, b);
    chk(b && rx == exp, {tag, " R3 status repeats"}, rx, exp);
    sel_off;
  endtask

  task automatic array_read(input logic [7:0] op, input logic [7:0] ad, input int n, input int pause_at);
    int base;
    base = {op[3], ad};
    sel_on;
    xfer(op, -1, rx, a, b);
    chk(!a, "R2 no drive during read opcode", a, 0);
    xfer(ad, -1, rx, a, b);
    chk(!a, "R2 no drive during address", a, 0);
    for (int j = 0; j < n; j++) begin
      xfer(8'h00, (j == 0) ? pause_at : -1, rx, a, b);
      chk(b && rx == pattern((base + j) % 512), "R4 read byte", rx, pattern((base + j) % 512));
    end
    sel_off;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, e;
    repeat (5) @(negedge clk);
    chk(spi_miso_oe == 1'b0, "R1 output enable low in reset", spi_miso_oe, 0);
    chk(wr_valid == 1'b0 && wr_commit == 1'b0, "R1 no write in reset", wr_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    status_read(8'hA8, "R1 latch clear after reset");

    cmd1(8'h06);
    status_read(8'hAA, "R5 latch set");
    cmd1(8'h04);
    status_read(8'hA8, "R5 latch cleared");
    sel_on; xfer(8'h06, -1, rx, a, b); xfer(8'h00, -1, rx, a, b); sel_off;
    status_read(8'hA8, "R5 extra bits cancel set");

    array_read(8'h0B, 8'hFE, 3, -1);   // wraps 1FF -> 000
    array_read(8'h03, 8'h10, 2, -1);

    // R6: no latch, nothing forwarded
    wq.delete(); c0 = commits;
    sel_on; xfer(8'h02, -1, rx, a, b); xfer(8'h20, -1, rx, a, b); xfer(8'h55, -1, rx, a, b); sel_off;
    chk(wq.size() == 0, "R6 no forward without latch", wq.size(), 0);
    chk(commits == c0, "R7 no commit without latch", commits, c0);

    // R6/R7: page write with in-page wrap
    cmd1(8'h06);
    wq.delete(); c0 = commits;
    sel_on;
    xfer(8'h0A, -1, rx, a, b); xfer(8'h3E, -1, rx, a, b);
    xfer(8'h11, -1, rx, a, b); xfer(8'h22, -1, rx, a, b); xfer(8'h33, -1, rx, a, b);
    chk(!a, "R2 no drive during write", a, 0);
    sel_off;
    chk(wq.size() == 3, "R6 forwarded byte count", wq.size(), 3);
    if (wq.size() == 3) begin
      e = {9'h13E, 8'h11}; chk(wq[0] == e, "R6 first byte", wq[0], e);
      e = {9'h13F, 8'h22}; chk(wq[1] == e, "R6 second byte", wq[1], e);
      e = {9'h130, 8'h33}; chk(wq[2] == e, "R6 page wrap", wq[2], e);
    end
    chk(commits == c0 + 1, "R7 commit pulse", commits, c0 + 1);
    status_read(8'hA8, "R7 latch cleared by commit");

    // R8: status write
    cmd1(8'h06);
    c0 = srw_cnt;
    sel_on; xfer(8'h01, -1, rx, a, b); xfer(8'h8C, -1, rx, a, b); sel_off;
    chk(srw_cnt == c0 + 1 && srw_last == 8'h8C, "R8 status write", srw_last, 8'h8C);
    status_read(8'hA8, "R8 latch cleared");

    // R9: unknown opcode
    cmd1(8'h06);
    wq.delete(); c0 = commits;
    sel_on; xfer(8'hFF, -1, rx, a, b); xfer(8'h12, -1, rx, a, b);
    chk(!a, "R9 unknown opcode stays silent", a, 0);
    sel_off;
    sel_on; xfer(8'h07, -1, rx, a, b); sel_off;
    chk(wq.size() == 0 && commits == c0, "R9 no write from unknown", wq.size(), 0);
    status_read(8'hAA, "R9 latch unchanged");
    cmd1(8'h04);

    // R10: busy
    busy = 1'b1;
    cmd1(8'h06);
    status_read(8'hA9, "R10 set ignored while busy");
    sel_on; xfer(8'h03, -1, rx, a, b); xfer(8'h00, -1, rx, a, b); xfer(8'h00, -1, rx, a, b);
    chk(!a, "R10 read ignored while busy", a, 0);
    sel_off;
    busy = 1'b0;
    status_read(8'hA8, "R10 latch still clear");

    // R11: pause during read and during write data
    array_read(8'h03, 8'h40, 2, 4);
    cmd1(8'h06);
    wq.delete();
    sel_on; xfer(8'h02, -1, rx, a, b); xfer(8'h50, -1, rx, a, b); xfer(8'hC3, 4, rx, a, b); sel_off;
    e = {9'h050, 8'hC3};
    chk(wq.size() == 1 && wq[0] == e, "R11 input ignored while paused",
        (wq.size() > 0) ? wq[0] : -1, e);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule